// File: doc/BRIEF.md
# DRAM and Expansion-Bus Refresh Sequencer

This block carries out one memory-refresh cycle for each periodic refresh request. The requests come from an interval timer that lives outside the block. In the processor-clock domain the block asks for the bus with `hold`. Once `hlda` is granted, it drives the active-low bus refresh strobe `ref_n`. It then starts a strobe sequence in a second domain, which runs on a 14.3 MHz reference clock. That domain drives the expansion-bus memory-read strobe `memr_n` and the DRAM `ras_n`, `cas_n` and `we_n` lines. When the sequence completes, the processor domain releases the strobe and the bus.

Two DRAM refresh modes are available and are chosen by `cfg_ras_only`:
- **CAS-before-RAS mode** leaves a two-clock precharge gap after the grant.
- **RAS-only mode** starts the strobe on the grant edge itself, keeps CAS idle and holds write-enable low.

The `memr_n` width is configurable in reference-clock cycles and can be stretched through `rdy`. RAS banks 1 and 2 fall one reference cycle after banks 0 and 3, which spreads the supply surge.

The address output carries three fields: an 11-bit row counter, zero in the middle bits, and an 8-bit page register at the top. An external bus master can also start a refresh by pulling `ext_ref_n` low. In that case the block runs only the memory-strobe and address sequence and never requests the bus. The block has no data stream, so all pins are plain level or pulse signals without valid/ready flow control. The only form of back-pressure is the `rdy` stretch of the read strobe.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset the outputs are idle:
  - `hold`=0
  - `ref_n`=1, `memr_n`=1, `cas_n`=1, `we_n`=1
  - `ras_n` all ones
  - `addr`=0 (row and page both zero)
- R2: A `refresh_req` pulse raises `hold`. With `cfg_ras_only`=0, `ref_n` falls on the third rising `clk` edge that samples `hlda` high. It therefore stays high for exactly two clock periods of granted bus.
- R3: With `cfg_ras_only`=1, `ref_n` falls on the first `clk` edge that samples `hlda` high. While `memr_n` is low, `cas_n` stays 1 and `we_n` stays 0.
- R4: With `cfg_ras_only`=0, `cas_n` is low for the whole time `memr_n` is low, and `we_n` equals the inverse of `cas_n` during that time.
- R5: With `rdy` high, `memr_n` stays low for max(`cfg_strobe_width`, 3) `rclk` cycles.
- R6: Each `rclk` edge that samples `rdy` low once the minimum width has been reached extends `memr_n` by one `rclk` cycle. `rdy` low before that point has no effect.
- R7: RAS banks 0 and 3 fall one `rclk` cycle before banks 1 and 2, so the pattern `ras_n`=4'b0110 appears between all-high and all-low.
- R8: `hold` falls on exactly the `clk` edge on which `ref_n` rises. Neither changes at any other point of the cycle end.
- R9: `addr[10:0]` holds the refresh row. It increments by one at the end of each refresh strobe and wraps modulo 2048.
- R10: A `page_we` pulse loads `page_din` into the page register shown on `addr[23:16]`. `addr[15:11]` is always zero.
- R11: A falling `ext_ref_n` runs the `memr_n` sequence without raising `hold` or driving `ref_n`. The row increments only when `ext_ref_n` returns high.
- R12: Requests that arrive while a cycle is in progress are counted and each one is served later, so no request is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset, processor domain |
| rclk | input | 1 | 14.3 MHz reference clock |
| rrst_n | input | 1 | Active-low reset, reference domain |
| refresh_req | input | 1 | One-cycle refresh request pulse |
| cfg_ras_only | input | 1 | 1 selects RAS-only mode, 0 selects CAS-before-RAS; static while a cycle runs |
| cfg_strobe_width | input | 4 | Read-strobe width in `rclk` cycles; values below 3 act as 3 |
| page_we | input | 1 | Page register write strobe |
| page_din | input | 8 | Page register write value |
| hlda | input | 1 | Bus grant |
| hold | output | 1 | Bus request |
| ref_n | output | 1 | Bus refresh strobe, active low |
| ext_ref_n | input | 1 | Refresh strobe driven by an external master, active low |
| rdy | input | 1 | Bus ready; low stretches `memr_n` |
| memr_n | output | 1 | Refresh memory-read strobe, active low |
| ras_n | output | 4 | DRAM row strobes, one per bank |
| cas_n | output | 1 | DRAM column strobe |
| we_n | output | 1 | DRAM write enable |
| addr | output | 24 | Refresh address: page, zero field, row |

## Verification
The hardest behaviour to reach from the ports is the `rdy` stretch at the exact edge where the minimum width runs out. It requires `rdy` to be low both before and after that edge, while the `memr_n` fall depends on a two-flop crossing with a variable phase. The stimulus therefore does not count from the request. It waits until `memr_n` is seen low on a falling `rclk` edge, then counts `rclk` edges from there before releasing `rdy`. This gives a width that can be predicted exactly. The queuing case is reached by issuing further pulses while `hold` is still up from the first one.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_HOLD,
    PS_GAP,
    PS_REF,
    PS_EXT,
    PS_EXTW
  } pstate_t;

  localparam int MIN_STROBE = 3;

endpackage

// File: rtl/rfs_sync.sv
module rfs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rfs_proc_ctl.sv
module rfs_proc_ctl
  import refresh_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int PAGE_W  = 8,
  parameter int PEND_W  = 3,
  parameter int GAP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_req,
  input  logic              cfg_ras_only,
  input  logic              hlda,
  input  logic              ext_ref_s,
  input  logic              done_s,
  input  logic              page_we,
  input  logic [PAGE_W-1:0] page_din,
  output logic              hold,
  output logic              ref_n,
  output logic              start_tgl,
  output logic [ROW_W-1:0]  row,
  output logic [PAGE_W-1:0] page
);

  localparam int                GW       = $clog2(GAP_CYC + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [GW-1:0]     GAP_LAST = GW'(GAP_CYC - 1);

  pstate_t           st_q;
  logic [PEND_W-1:0] pend_q;
  logic [GW-1:0]     gap_q;
  logic              ext_prev_q;
  logic              done_prev_q;
  logic              done_evt;
  logic              ext_fall;
  logic              take;
  logic              inc;

  always_comb begin
    done_evt = done_s ^ done_prev_q;
    ext_fall = ext_prev_q & ~ext_ref_s;
    take     = (st_q == PS_IDLE) && !ext_fall && (pend_q != '0);
    inc      = refresh_req && (pend_q != PEND_MAX);
  end

  // pending request counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pend_q <= '0;
    else if (inc && !take)  pend_q <= pend_q + 1'b1;
    else if (!inc && take)  pend_q <= pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q  <= 1'b1;
      done_prev_q <= 1'b0;
      page        <= '0;
    end else begin
      ext_prev_q  <= ext_ref_s;
      done_prev_q <= done_s;
      if (page_we) page <= page_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PS_IDLE;
      hold      <= 1'b0;
      ref_n     <= 1'b1;
      start_tgl <= 1'b0;
      gap_q     <= '0;
      row       <= '0;
    end else begin
      case (st_q)
        PS_IDLE: begin
          if (ext_fall) begin
            st_q      <= PS_EXT;
            start_tgl <= ~start_tgl;
          end else if (take) begin
            st_q <= PS_HOLD;
            hold <= 1'b1;
          end
        end
        PS_HOLD: begin
          if (hlda) begin
            if (cfg_ras_only) begin
              st_q      <= PS_REF;
              ref_n     <= 1'b0;
              start_tgl <= ~start_tgl;
            end else begin
              st_q  <= PS_GAP;
              gap_q <= '0;
            end
          end
        end
        PS_GAP: begin
          if (gap_q == GAP_LAST) begin
            st_q      <= PS_REF;
            ref_n     <= 1'b0;
            start_tgl <= ~start_tgl;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        PS_REF: begin
          if (done_evt) begin
            st_q  <= PS_IDLE;
            ref_n <= 1'b1;
            hold  <= 1'b0;
            row   <= row + 1'b1;
          end
        end
        PS_EXT: begin
          if (done_evt) st_q <= PS_EXTW;
        end
        PS_EXTW: begin
          if (ext_ref_s) begin
            st_q <= PS_IDLE;
            row  <= row + 1'b1;
          end
        end
        default: st_q <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rfs_ref_seq.sv
module rfs_ref_seq
  import refresh_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int WID_W = 4
) (
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             start_s,
  input  logic             cfg_ras_only,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             rdy,
  output logic             memr_n,
  output logic [BANKS-1:0] ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             done_tgl
);

  localparam logic [WID_W-1:0] MIN_W   = WID_W'(MIN_STROBE);
  localparam logic [WID_W-1:0] CNT_MAX = '1;

  logic             start_prev_q;
  logic             active_q;
  logic [WID_W-1:0] cnt_q;
  logic             early_q;
  logic             late_q;
  logic             start_evt;
  logic [WID_W-1:0] eff_w;
  logic             finish;

  always_comb begin
    start_evt = start_s ^ start_prev_q;
    eff_w     = (cfg_width < MIN_W) ? MIN_W : cfg_width;
    finish    = active_q && (cnt_q >= eff_w) && rdy;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      start_prev_q <= 1'b0;
      active_q     <= 1'b0;
      cnt_q        <= '0;
      early_q      <= 1'b0;
      late_q       <= 1'b0;
      memr_n       <= 1'b1;
      cas_n        <= 1'b1;
      done_tgl     <= 1'b0;
    end else begin
      start_prev_q <= start_s;
      if (!active_q) begin
        if (start_evt) begin
          active_q <= 1'b1;
          memr_n   <= 1'b0;
          cas_n    <= cfg_ras_only;
          cnt_q    <= WID_W'(1);
        end
      end else if (finish) begin
        active_q <= 1'b0;
        memr_n   <= 1'b1;
        cas_n    <= 1'b1;
        early_q  <= 1'b0;
        late_q   <= 1'b0;
        done_tgl <= ~done_tgl;
      end else begin
        if (cnt_q == WID_W'(1)) early_q <= 1'b1;
        if (cnt_q == WID_W'(2)) late_q  <= 1'b1;
        if (cnt_q != CNT_MAX)   cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!active_q)         we_n = 1'b1;
    else if (cfg_ras_only) we_n = 1'b0;
    else                   we_n = ~cas_n;
  end

  // banks 1 and 2 (of every group of four) are the delayed ones
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam bit LATE = ((b % 4) == 1) || ((b % 4) == 2);
    if (LATE) begin : g_late
      assign ras_n[b] = ~late_q;
    end else begin : g_early
      assign ras_n[b] = ~early_q;
    end
  end

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int ROW_W       = 11,
  parameter int PAGE_W      = 8,
  parameter int ADDR_W      = 24,
  parameter int WID_W       = 4,
  parameter int RAS_BANKS   = 4,
  parameter int PEND_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HLDA_GAP    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rclk,
  input  logic                 rrst_n,
  input  logic                 refresh_req,
  input  logic                 cfg_ras_only,
  input  logic [WID_W-1:0]     cfg_strobe_width,
  input  logic                 page_we,
  input  logic [PAGE_W-1:0]    page_din,
  input  logic                 hlda,
  output logic                 hold,
  output logic                 ref_n,
  input  logic                 ext_ref_n,
  input  logic                 rdy,
  output logic                 memr_n,
  output logic [RAS_BANKS-1:0] ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic [ADDR_W-1:0]    addr
);

  localparam int MID_W = ADDR_W - ROW_W - PAGE_W;

  logic              start_tgl;
  logic              start_s;
  logic              done_tgl;
  logic              done_s;
  logic              ext_s;
  logic [ROW_W-1:0]  row;
  logic [PAGE_W-1:0] page;

  rfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_start_sync (
    .clk(rclk), .rst_n(rrst_n), .d(start_tgl), .q(start_s)
  );

  rfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d(done_tgl), .q(done_s)
  );

  rfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_ref_n), .q(ext_s)
  );

  rfs_proc_ctl #(
    .ROW_W(ROW_W), .PAGE_W(PAGE_W), .PEND_W(PEND_W), .GAP_CYC(HLDA_GAP)
  ) u_proc (
    .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req),
    .cfg_ras_only(cfg_ras_only), .hlda(hlda), .ext_ref_s(ext_s),
    .done_s(done_s), .page_we(page_we), .page_din(page_din),
    .hold(hold), .ref_n(ref_n), .start_tgl(start_tgl),
    .row(row), .page(page)
  );

  rfs_ref_seq #(.BANKS(RAS_BANKS), .WID_W(WID_W)) u_seq (
    .rclk(rclk), .rrst_n(rrst_n), .start_s(start_s),
    .cfg_ras_only(cfg_ras_only), .cfg_width(cfg_strobe_width), .rdy(rdy),
    .memr_n(memr_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .done_tgl(done_tgl)
  );

  assign addr = {page, {MID_W{1'b0}}, row};

endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rclk,
  input logic        rrst_n,
  input logic        cfg_ras_only,
  input logic        hlda,
  input logic        hold,
  input logic        ref_n,
  input logic        memr_n,
  input logic [3:0]  ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [23:0] addr
);

  // R2
  cbr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ref_n) && !cfg_ras_only) |-> ($past(hlda, 1) && $past(hlda, 2) && $past(hlda, 3)));

  // R2
  ref_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_n |-> hold);

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $rose(ref_n));

  // R3
  ras_only_pins_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!memr_n && cfg_ras_only) |-> (cas_n && !we_n));

  // R4
  cbr_cas_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!memr_n && !cfg_ras_only) |-> (!cas_n && we_n));

  // R5
  min_width_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(memr_n) |-> (!$past(memr_n, 2) && !$past(memr_n, 3)));

  // R7
  stagger_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    $fell(ras_n[1]) |-> (!$past(ras_n[0]) && !$past(ras_n[3])));

  // R10
  mid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[15:11] == 5'd0);

endmodule

bind refresh_sequencer refresh_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rclk(rclk), .rrst_n(rrst_n),
  .cfg_ras_only(cfg_ras_only), .hlda(hlda), .hold(hold), .ref_n(ref_n),
  .memr_n(memr_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
);

// File: tb/refresh_sequencer_bench.sv
`timescale 1ns/1ps
module refresh_sequencer_bench;

  logic        clk = 1'b0;
  logic        rclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rrst_n = 1'b0;
  logic        refresh_req = 1'b0;
  logic        cfg_ras_only = 1'b0;
  logic [3:0]  cfg_strobe_width = 4'd4;
  logic        page_we = 1'b0;
  logic [7:0]  page_din = 8'd0;
  logic        hlda = 1'b0;
  logic        hold;
  logic        ref_n;
  logic        ext_ref_n = 1'b1;
  logic        rdy = 1'b1;
  logic        memr_n;
  logic [3:0]  ras_n;
  logic        cas_n;
  logic        we_n;
  logic [23:0] addr;

  int checks = 0;
  int failures = 0;
  int memr_cnt = 0;
  int gap_cnt = 0;
  int hold_rises = 0;
  int r4_bad = 0;
  int r3_bad = 0;
  int r8_bad = 0;
  bit saw_stagger = 0;
  logic hold_p = 1'b0;
  logic ref_p = 1'b1;

  always #10 clk = ~clk;
  always #35 rclk = ~rclk;

  refresh_sequencer u_refresh_sequencer (
    .clk(clk), .rst_n(rst_n), .rclk(rclk), .rrst_n(rrst_n),
    .refresh_req(refresh_req), .cfg_ras_only(cfg_ras_only),
    .cfg_strobe_width(cfg_strobe_width), .page_we(page_we),
    .page_din(page_din), .hlda(hlda), .hold(hold), .ref_n(ref_n),
    .ext_ref_n(ext_ref_n), .rdy(rdy), .memr_n(memr_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

  // monitors, reference domain
  always @(negedge rclk) begin
    if (!memr_n) begin
      memr_cnt++;
      if (cfg_ras_only && (!cas_n || we_n)) r3_bad++;
      if (!cfg_ras_only && (cas_n || (we_n != ~cas_n))) r4_bad++;
    end
    if (ras_n == 4'b0110) saw_stagger = 1'b1;
  end

  // monitors, processor domain
  always @(negedge clk) begin
    if (hold && hlda && ref_n) gap_cnt++;
    if (hold && !hold_p) hold_rises++;
    if ((hold_p && !hold) != (!ref_p && ref_n)) r8_bad++;
    hold_p = hold;
    ref_p  = ref_n;
  end

  // bus grant follows the request
  initial begin
    forever begin
      @(negedge clk);
      #2 hlda = hold;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    memr_cnt = 0; gap_cnt = 0; r3_bad = 0; r4_bad = 0; saw_stagger = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk) refresh_req = 1'b1;
    @(negedge clk) refresh_req = 1'b0;
  endtask

  task automatic wait_cycle_end();
    int g = 0;
    while (!hold && g < 2000) begin @(negedge clk); g++; end
    while (hold && g < 4000) begin @(negedge clk); g++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rrst_n = 1'b0;
    repeat (5) @(negedge rclk);
    rst_n = 1'b1; rrst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!hold && ref_n, "R1 hold/ref_n", {hold, ref_n}, 1);
    chk(memr_n && cas_n && we_n, "R1 memr/cas/we", {memr_n, cas_n, we_n}, 7);
    chk(ras_n == 4'hF, "R1 ras_n", ras_n, 15);
    chk(addr == 24'd0, "R1 addr", addr, 0);
  endtask

  task automatic t_cbr();
    int r0;
    cfg_ras_only = 1'b0; cfg_strobe_width = 4'd4; rdy = 1'b1;
    r0 = addr[10:0];
    clear_mon();
    pulse_req();
    wait_cycle_end();
    chk(gap_cnt == 2, "R2 cbr grant gap", gap_cnt, 2);
    chk(memr_cnt == 4, "R5 width 4", memr_cnt, 4);
    chk(r4_bad == 0, "R4 cas/we during strobe", r4_bad, 0);
    chk(saw_stagger, "R7 stagger seen", saw_stagger, 1);
    chk(ras_n == 4'hF, "R7 ras released", ras_n, 15);
    chk(addr[10:0] == 11'(r0 + 1), "R9 row step", addr[10:0], r0 + 1);
  endtask

  task automatic t_min_width();
    clear_mon();
    cfg_strobe_width = 4'd1;
    pulse_req();
    wait_cycle_end();
    chk(memr_cnt == 3, "R5 width floor", memr_cnt, 3);
    cfg_strobe_width = 4'd4;
  endtask

  task automatic t_rdy();
    int g = 0;
    clear_mon();
    cfg_strobe_width = 4'd5;
    rdy = 1'b0;
    pulse_req();
    while (memr_n && g < 2000) begin @(negedge rclk); g++; end
    repeat (7) @(posedge rclk);
    @(negedge rclk) rdy = 1'b1;
    wait_cycle_end();
    chk(memr_cnt == 8, "R6 ready stretch", memr_cnt, 8);
    cfg_strobe_width = 4'd4;
  endtask

  task automatic t_ras_only();
    int r0;
    clear_mon();
    cfg_ras_only = 1'b1;
    r0 = addr[10:0];
    pulse_req();
    wait_cycle_end();
    chk(gap_cnt == 0, "R3 no grant gap", gap_cnt, 0);
    chk(r3_bad == 0, "R3 cas high we low", r3_bad, 0);
    chk(memr_cnt == 4, "R3 strobe ran", memr_cnt, 4);
    chk(addr[10:0] == 11'(r0 + 1), "R9 row step ras-only", addr[10:0], r0 + 1);
    cfg_ras_only = 1'b0;
  endtask

  task automatic t_page();
    @(negedge clk) begin page_we = 1'b1; page_din = 8'hA5; end
    @(negedge clk) page_we = 1'b0;
    @(negedge clk);
    chk(addr[23:16] == 8'hA5, "R10 page field", addr[23:16], 8'hA5);
    chk(addr[15:11] == 5'd0, "R10 middle zero", addr[15:11], 0);
  endtask

  task automatic t_ext();
    int r0, h0, g;
    clear_mon();
    r0 = addr[10:0]; h0 = hold_rises; g = 0;
    @(negedge clk) ext_ref_n = 1'b0;
    while (memr_n && g < 2000) begin @(negedge rclk); g++; end
    while (!memr_n && g < 4000) begin @(negedge rclk); g++; end
    repeat (6) @(negedge clk);
    chk(memr_cnt == 4, "R11 ext strobe", memr_cnt, 4);
    chk(hold_rises == h0, "R11 no hold", hold_rises - h0, 0);
    chk(ref_n, "R11 ref_n idle", ref_n, 1);
    chk(addr[10:0] == 11'(r0), "R11 row waits", addr[10:0], r0);
    @(negedge clk) ext_ref_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(addr[10:0] == 11'(r0 + 1), "R11 row after release", addr[10:0], r0 + 1);
  endtask

  task automatic t_queue();
    int r0, h0, g;
    r0 = addr[10:0]; h0 = hold_rises; g = 0;
    pulse_req();
    repeat (3) @(negedge clk);
    pulse_req();
    repeat (3) @(negedge clk);
    pulse_req();
    while (addr[10:0] != 11'(r0 + 3) && g < 5000) begin @(negedge clk); g++; end
    repeat (200) @(negedge clk);
    chk(addr[10:0] == 11'(r0 + 3), "R12 all served", addr[10:0], r0 + 3);
    chk(hold_rises - h0 == 3, "R12 hold count", hold_rises - h0, 3);
    chk(r8_bad == 0, "R8 hold/ref_n edges", r8_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_cbr();
    t_min_width();
    t_rdy();
    t_ras_only();
    t_page();
    t_ext();
    t_queue();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule